// File: doc/BRIEF.md
# Indexed Register Window with Interrupt Gate

This block gives a host a two-location view onto a 128-byte register space. The host first writes an index to the address location. It then reads or writes the chosen byte through the data location. The index stays in place across any number of data accesses, so one index write can serve a read-modify-write sequence.

The lowest fourteen indices belong to a separate clock core. For those indices the block passes on the index, the write data and one-cycle read and write strobes, and it returns the core's read data. The other 114 indices are served from a byte store inside the block, which clears on reset. The system decides what these bytes mean. By convention, index 0x0E holds a diagnostic status byte.

The top bit of each address-location write is not part of the index. It drives a gate for the non-maskable interrupt line: a 1 closes the gate and a 0 opens it. The NMI output is the OR of all error inputs, ANDed with the gate. It is not affected by any ordinary interrupt masking.

Top module: `idx_data_gateway`

## Requirements
- R1: After reset the index is 0, the gate is closed (so `nmi_out` is 0 even with every error input high), and every byte of the internal store reads as 0x00.
- R2: A write with `bus_sel`=0 loads the index from `bus_wdata[6:0]` at the clock edge. The index keeps that value through any data-location reads and writes until the next address-location write.
- R3: On a write with `bus_sel`=0, `bus_wdata[7]`=1 closes the gate and `bus_wdata[7]`=0 opens it. The gate setting takes effect from the clock edge of that write.
- R4: `nmi_out` is 1 in the same cycle exactly when the gate is open and at least one bit of `err_in` is 1.
- R5: A write with `bus_sel`=1 and index 0x0E..0x7F changes only the selected store byte, at the clock edge. All other store bytes keep their values. Both ends of the range, 0x0E and 0x7F, behave this way.
- R6: While the index is 0x00..0x0D, a data write raises `core_wr` for that cycle with `core_wdata`=`bus_wdata`, and a data read raises `core_rd` for that cycle. `core_idx` carries the index's low four bits. Neither strobe is raised for any other index or for address-location accesses. A core write leaves the store unchanged.
- R7: When `bus_rd`=1 and `bus_sel`=1 and `bus_wr`=0, `bus_rdata` shows the selected byte in the same cycle: `core_rdata` for indices 0x00..0x0D, and the store byte otherwise. In all other cycles `bus_rdata` is 0x00. When `bus_wr` and `bus_rd` are both 1, the cycle is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | 0 selects the address location, 1 the data location |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (valid in the same cycle) |
| core_idx | output | 4 | Register index forwarded to the clock core |
| core_wr | output | 1 | Write strobe to the clock core |
| core_rd | output | 1 | Read strobe to the clock core |
| core_wdata | output | 8 | Write data to the clock core |
| core_rdata | input | 8 | Read data from the clock core |
| err_in | input | ERR_W (4) | Error sources for the non-maskable interrupt |
| nmi_out | output | 1 | Gated non-maskable interrupt |

## Verification
Random address writes set the index anywhere in the full 7-bit range, with the gate bit chosen at random. The data writes and reads between them then fall into both the core range and the store range. This separates forwarding from local storage. Random `err_in` patterns are applied together with gate changes, which shows whether the NMI follows the gate and not the error inputs alone. Directed cases cover:
- the two sides of the 0x0D/0x0E boundary and index 0x7F;
- index writes with bit 7 set, which must not leak into the index;
- cycles with both strobes set;
- a full sweep of the store after reset and again at the end, which catches writes that landed on the wrong byte.

// File: rtl/gw_pkg.sv
package gw_pkg;

    localparam int IDX_W     = 7;
    localparam int DATA_W    = 8;
    localparam int CORE_CNT  = 14;
    localparam int REG_CNT   = 1 << IDX_W;
    localparam int STORE_CNT = REG_CNT - CORE_CNT;
    localparam int CORE_IW   = $clog2(CORE_CNT);

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_IDX_WR,
        ACC_DATA_WR,
        ACC_DATA_RD
    } acc_e;

    typedef struct packed {
        acc_e  kind;
        logic  core_hit;
        byte_t wdata;
    } acc_t;

    function automatic logic in_core(idx_t i);
        return int'(i) < CORE_CNT;
    endfunction

    function automatic acc_e classify(logic sel, logic wr, logic rd);
        if (wr)
            return sel ? ACC_DATA_WR : ACC_IDX_WR;
        else if (rd && sel)
            return ACC_DATA_RD;
        else
            return ACC_NONE;
    endfunction

endpackage

// File: rtl/gw_index_latch.sv
module gw_index_latch
    import gw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t wdata,
    output idx_t  idx,
    output logic  gate_open
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            gate_open <= 1'b0;
        end else if (load) begin
            idx       <= wdata[IDX_W-1:0];
            gate_open <= ~wdata[DATA_W-1];
        end
    end
endmodule

// File: rtl/gw_byte_store.sv
module gw_byte_store
    import gw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  idx,
    input  byte_t wdata,
    output byte_t rdata
);
    byte_t cells [STORE_CNT];

    for (genvar g = 0; g < STORE_CNT; g++) begin : g_cell
        localparam idx_t MY_IDX = idx_t'(g + CORE_CNT);
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (we && idx == MY_IDX)
                cells[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < STORE_CNT; k++) begin
            if (idx == idx_t'(k + CORE_CNT))
                rdata = cells[k];
        end
    end
endmodule

// File: rtl/gw_nmi_gate.sv
module gw_nmi_gate #(
    parameter int ERR_W = 4
) (
    input  logic [ERR_W-1:0] err_in,
    input  logic             gate_open,
    output logic             nmi_out
);
    assign nmi_out = gate_open & (|err_in);
endmodule

// File: rtl/idx_data_gateway.sv
module idx_data_gateway
    import gw_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic [3:0]         core_idx,
    output logic               core_wr,
    output logic               core_rd,
    output logic [7:0]         core_wdata,
    input  logic [7:0]         core_rdata,
    input  logic [ERR_W-1:0]   err_in,
    output logic               nmi_out
);
    idx_t  cur_idx;
    logic  gate_open;
    byte_t store_rdata;
    acc_t  acc;

    always_comb begin
        acc.kind     = classify(bus_sel, bus_wr, bus_rd);
        acc.core_hit = in_core(cur_idx);
        acc.wdata    = bus_wdata;
    end

    gw_index_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (acc.kind == ACC_IDX_WR),
        .wdata     (acc.wdata),
        .idx       (cur_idx),
        .gate_open (gate_open)
    );

    gw_byte_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (acc.kind == ACC_DATA_WR && !acc.core_hit),
        .idx   (cur_idx),
        .wdata (acc.wdata),
        .rdata (store_rdata)
    );

    gw_nmi_gate #(.ERR_W(ERR_W)) u_nmi (
        .err_in    (err_in),
        .gate_open (gate_open),
        .nmi_out   (nmi_out)
    );

    assign core_idx   = cur_idx[CORE_IW-1:0];
    assign core_wdata = acc.wdata;
    assign core_wr    = (acc.kind == ACC_DATA_WR) && acc.core_hit;
    assign core_rd    = (acc.kind == ACC_DATA_RD) && acc.core_hit;

    always_comb begin
        if (acc.kind != ACC_DATA_RD)
            bus_rdata = '0;
        else if (acc.core_hit)
            bus_rdata = core_rdata;
        else
            bus_rdata = store_rdata;
    end
endmodule

// File: rtl/gw_checker.sv
module gw_checker #(
    parameter int ERR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic             core_wr,
    input logic             core_rd,
    input logic [ERR_W-1:0] err_in,
    input logic             nmi_out,
    input logic [6:0]       cur_idx,
    input logic             gate_open
);
    // R2: index loads from the low seven bits of an address write
    p_idx_load_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_sel) |=> cur_idx == $past(bus_wdata[6:0]));

    // R2: index holds when no address write occurs
    p_idx_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && !bus_sel) |=> $stable(cur_idx));

    // R3: gate follows the inverse of bit 7
    p_gate_set_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_sel) |=> gate_open == !$past(bus_wdata[7]));

    // R4: a closed gate blocks the NMI
    p_nmi_block_r4: assert property (@(posedge clk) disable iff (rst)
        !gate_open |-> !nmi_out);

    // R4: an open gate passes any error
    p_nmi_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (gate_open && err_in != '0) |-> nmi_out);

    // R6: core strobes only for data accesses inside the core range
    p_core_wr_r6: assert property (@(posedge clk) disable iff (rst)
        core_wr |-> (bus_sel && bus_wr && cur_idx < 7'd14));

    p_core_rd_r6: assert property (@(posedge clk) disable iff (rst)
        core_rd |-> (bus_sel && bus_rd && !bus_wr && cur_idx < 7'd14));

    p_core_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(core_wr && core_rd));

    // R7: read data is zero outside data reads
    p_rdata_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_sel && !bus_wr) |-> bus_rdata == 8'h00);
endmodule

bind idx_data_gateway gw_checker #(.ERR_W(ERR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .core_wr   (core_wr),
    .core_rd   (core_rd),
    .err_in    (err_in),
    .nmi_out   (nmi_out),
    .cur_idx   (cur_idx),
    .gate_open (gate_open)
);

// File: tb/idx_data_gateway_tb.sv
module idx_data_gateway_tb;
    localparam int ERR_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]       bus_wdata = 8'h00;
    logic [7:0]       bus_rdata;
    logic [3:0]       core_idx;
    logic             core_wr, core_rd;
    logic [7:0]       core_wdata;
    logic [7:0]       core_rdata;
    logic [ERR_W-1:0] err_in = '0;
    logic             nmi_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [6:0] m_idx;
    logic       m_gate;
    logic [7:0] m_mem [128];

    always #10 clk = ~clk;

    idx_data_gateway #(.ERR_W(ERR_W)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_idx(core_idx), .core_wr(core_wr), .core_rd(core_rd),
        .core_wdata(core_wdata), .core_rdata(core_rdata),
        .err_in(err_in), .nmi_out(nmi_out)
    );

    // stand-in clock core: returns a value derived from the index
    function automatic logic [7:0] core_val(logic [3:0] i);
        return {4'hA, i};
    endfunction
    assign core_rdata = core_val(core_idx);

    function automatic logic [7:0] exp_rdata(logic sel, logic wr, logic rd);
        if (!(sel && rd && !wr)) return 8'h00;
        if (m_idx < 7'd14) return core_val(m_idx[3:0]);
        return m_mem[m_idx];
    endfunction

    task automatic check(logic ok, string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // one bus cycle: drive at negedge, check outputs mid-cycle, update model at posedge
    task automatic op(logic sel, logic wr, logic rd, logic [7:0] wd, logic [ERR_W-1:0] errs);
        logic core;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_wdata = wd; err_in = errs;
        #5;
        core = (m_idx < 7'd14);
        check(nmi_out == (m_gate && errs != '0), "R4 nmi", nmi_out, m_gate && errs != '0);
        check(bus_rdata == exp_rdata(sel, wr, rd), "R7 rdata", bus_rdata, exp_rdata(sel, wr, rd));
        check(core_wr == (sel && wr && core), "R6 core_wr", core_wr, sel && wr && core);
        check(core_rd == (sel && rd && !wr && core), "R6 core_rd", core_rd, sel && rd && !wr && core);
        if (sel && wr && core)
            check(core_wdata == wd && core_idx == m_idx[3:0], "R6 core fwd",
                  {core_idx, core_wdata}, {m_idx[3:0], wd});
        @(posedge clk);
        if (wr && !sel) begin
            m_idx  = wd[6:0];
            m_gate = !wd[7];
        end else if (wr && sel && !core) begin
            m_mem[m_idx] = wd;
        end
    endtask

    task automatic idle();
        op(1'b0, 1'b0, 1'b0, 8'h00, '0);
    endtask

    task automatic sweep_store(string tag);
        for (int i = 14; i < 128; i++) begin
            op(1'b0, 1'b1, 1'b0, 8'h80 | 8'(i), '0);
            op(1'b1, 1'b0, 1'b1, 8'h00, '0);
        end
        idle();
        check(1'b1, tag, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_idx = '0; m_gate = 1'b0;
        for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: gate closed with all errors high, index 0 visible via data read
        op(1'b1, 1'b0, 1'b1, 8'h00, '1);
        check(nmi_out == 1'b0, "R1 nmi closed after reset", nmi_out, 0);
        check(core_idx == 4'd0, "R1 index zero", core_idx, 0);
        // R1: store zero everywhere (read checks inside compare against zeroed model)
        sweep_store("R1 store sweep");

        // R3: open gate, error passes; close, blocked
        op(1'b0, 1'b1, 1'b0, 8'h0E, 4'b0010);
        op(1'b0, 1'b0, 1'b0, 8'h00, 4'b0010);
        check(nmi_out == 1'b1, "R3 gate open", nmi_out, 1);
        op(1'b0, 1'b1, 1'b0, 8'h8E, 4'b1000);
        op(1'b0, 1'b0, 1'b0, 8'h00, 4'b1000);
        check(nmi_out == 1'b0, "R3 gate closed", nmi_out, 0);

        // R2: bit 7 excluded from index; data accesses keep index
        op(1'b0, 1'b1, 1'b0, 8'hFF, '0);          // index 0x7F, gate closed
        op(1'b1, 1'b1, 1'b0, 8'h5A, '0);          // R5 top boundary
        op(1'b1, 1'b0, 1'b1, 8'h00, '0);
        op(1'b1, 1'b1, 1'b0, 8'hC3, '0);
        op(1'b1, 1'b0, 1'b1, 8'h00, '0);
        check(m_idx == 7'h7F, "R2 index held", m_idx, 7'h7F);

        // R5/R6: boundary 0x0D vs 0x0E
        op(1'b0, 1'b1, 1'b0, 8'h0D, '0);
        op(1'b1, 1'b1, 1'b0, 8'h77, '0);          // to core, store untouched
        op(1'b1, 1'b0, 1'b1, 8'h00, '0);
        op(1'b0, 1'b1, 1'b0, 8'h0E, '0);
        op(1'b1, 1'b0, 1'b1, 8'h00, '0);          // still zero
        op(1'b1, 1'b1, 1'b0, 8'h3C, '0);
        op(1'b1, 1'b0, 1'b1, 8'h00, '0);
        // R7: both strobes treated as write
        op(1'b1, 1'b1, 1'b1, 8'h99, '0);
        op(1'b1, 1'b0, 1'b1, 8'h00, '0);
        // address-port read returns zero
        op(1'b0, 1'b0, 1'b1, 8'h00, '0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int k;
            logic [7:0] wd;
            logic [ERR_W-1:0] e;
            k  = int'($urandom_range(0, 9));
            wd = 8'($urandom);
            e  = ERR_W'($urandom_range(0, 3) == 0 ? $urandom : 0);
            if (k < 2)      op(1'b0, 1'b1, 1'b0, wd, e);
            else if (k < 5) op(1'b1, 1'b1, 1'b0, wd, e);
            else if (k < 9) op(1'b1, 1'b0, 1'b1, wd, e);
            else            op(1'b1, 1'b1, 1'b1, wd, e);
        end
        idle();

        // R5: final sweep shows no stray writes
        sweep_store("R5 final sweep");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule